// File: doc/BRIEF.md
# Multi-Mode Phase Accumulator Counter

The block is one counter channel for a large chip. In its oscillator mode it keeps a 32-bit phase value and adds a programmable step to it on each accumulation tick. The tick is either the system clock or the system clock slowed down by a power-of-two prescaler. An optional ceiling value makes the phase return to zero early, and the output toggles on each such return. This gives an exact divide-by-n output that does not depend on bit 31.

Two other modes turn the same phase register into an event counter. The gated mode counts rising edges of input A only while input B is high. The quadrature mode decodes A/B as an incremental encoder and counts up or down. Each input can be taken from its own pin or from the output of a neighbouring counter, so channels can be chained. Software programs the cell through a single-cycle write port and reads the phase on a dedicated output.

Top module: `nco_counter_cell`

## Requirements
- R1: After reset the phase output reads 0, the output pin reads 0 and the mode is off.
- R2: In oscillator mode (control bits [1:0] = 1) with prescale select 0, the phase grows by the step value on every clock edge after the mode is written.
- R3: Control bits [4:2] = k, with k from 1 to 4, make accumulation happen once every 2^k clocks. The divider restarts on every control write, so the first add lands 2^k edges after that write. Values 5 to 7 act as 4.
- R4: With a nonzero ceiling, an add whose 33-bit sum reaches or passes the ceiling sets the phase to 0 and inverts the output pin.
- R5: With the ceiling at 0, the phase wraps modulo 2^32 and the output pin equals phase bit 31 after every edge.
- R6: In gated mode (control = 2), each rising edge of A adds 1 while B is high. Rising edges while B is low add nothing, and falling edges add nothing.
- R7: In quadrature mode (control = 3), the sequence {A,B} = 00,10,11,01 counts up and the reverse sequence counts down. A step where both inputs change at once leaves the count unchanged.
- R8: Control bit 5 routes the partner input in place of pin A, and control bit 6 does the same for pin B. A deselected pin has no effect.
- R9: A phase write (address 2) takes priority over accumulation in the same cycle. The written value appears unmodified after that edge.
- R10: With mode 0, the phase holds its value whatever the inputs do.
- R11: An input change reaches the count through two synchronizer flops and one history flop. It first shows on the phase output after the third rising clock edge.

Register addresses: 0 control, 1 step, 2 phase, 3 ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 32 | Write data |
| pin_a_i | input | 1 | Pin input A, asynchronous |
| pin_b_i | input | 1 | Pin input B, asynchronous |
| partner_i | input | 1 | Output of the neighbouring counter |
| phs_o | output | 32 | Current phase/count |
| out_o | output | 1 | Registered counter output |

## Verification
A wrong accumulator, prescaler or ceiling comparison shows on the phase output at the first tick after the mode write. That is one edge later at prescale 0 and up to 16 edges later at the slowest setting. A corrupted edge history or quadrature direction shows as a count that is off by one or has the wrong sign, three edges after the input moves. An output flop that is out of step with the ceiling logic shows on the output pin at the first rollover.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_NCO   = 2'd1,
    MODE_GATED = 2'd2,
    MODE_QUAD  = 2'd3
  } mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FRQ  = 2'd1;
  localparam logic [1:0] ADDR_PHS  = 2'd2;
  localparam logic [1:0] ADDR_MAX  = 2'd3;

  localparam int CTRL_PSEL_LSB = 2;
  localparam int CTRL_SRCA_BIT = 5;
  localparam int CTRL_SRCB_BIT = 6;
endpackage

// File: rtl/nco_sync.sv
module nco_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/nco_prescaler.sv
module nco_prescaler #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  int unsigned      sel_eff;

  always_comb begin
    sel_eff = (int'(sel_i) > CNT_W) ? CNT_W : int'(sel_i);
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < sel_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = ((cnt_q & mask) == mask);
endmodule

// File: rtl/nco_quad_step.sv
module nco_quad_step (
  input  logic [1:0] prev_i,  // {b,a}
  input  logic [1:0] cur_i,   // {b,a}
  output logic       up_o,
  output logic       dn_o
);
  logic one_change;
  logic fwd;

  // exactly one input moved; two moving at once is not a legal step
  assign one_change = ^(prev_i ^ cur_i);
  // A leading B: new A differs from old B
  assign fwd  = cur_i[0] ^ prev_i[1];
  assign up_o = one_change & fwd;
  assign dn_o = one_change & ~fwd;
endmodule

// File: rtl/nco_counter_cell.sv
module nco_counter_cell
  import nco_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         pin_a_i,
  input  logic         pin_b_i,
  input  logic         partner_i,
  output logic [W-1:0] phs_o,
  output logic         out_o
);
  localparam int SEL_W = $clog2(PRESC_W + 1);

  mode_e            mode_q;
  logic [SEL_W-1:0] psel_q;
  logic             src_a_q, src_b_q;
  logic [W-1:0]     frq_q, phs_q, max_q, phs_d;
  logic             out_q, out_d, wrap;
  logic [W:0]       sum;
  logic [1:0]       ab_raw, ab_s, ab_q;
  logic             tick, rose_a, q_up, q_dn;
  logic             wr_ctrl, wr_frq, wr_phs, wr_max;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_frq  = wr_en_i && (wr_addr_i == ADDR_FRQ);
  assign wr_phs  = wr_en_i && (wr_addr_i == ADDR_PHS);
  assign wr_max  = wr_en_i && (wr_addr_i == ADDR_MAX);

  assign ab_raw[0] = src_a_q ? partner_i : pin_a_i;
  assign ab_raw[1] = src_b_q ? partner_i : pin_b_i;

  nco_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ab_raw),
    .q_o   (ab_s)
  );

  nco_prescaler #(.CNT_W(PRESC_W), .SEL_W(SEL_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wr_ctrl),
    .sel_i (psel_q),
    .tick_o(tick)
  );

  nco_quad_step u_quad (
    .prev_i(ab_q),
    .cur_i (ab_s),
    .up_o  (q_up),
    .dn_o  (q_dn)
  );

  assign rose_a = ab_s[0] & ~ab_q[0];
  assign sum    = {1'b0, phs_q} + {1'b0, frq_q};

  always_comb begin
    phs_d = phs_q;
    wrap  = 1'b0;
    unique case (mode_q)
      MODE_NCO: if (tick) begin
        if ((max_q != '0) && (sum >= {1'b0, max_q})) begin
          phs_d = '0;
          wrap  = 1'b1;
        end else begin
          phs_d = sum[W-1:0];
        end
      end
      MODE_GATED: if (rose_a && ab_s[1]) phs_d = phs_q + 1'b1;
      MODE_QUAD: begin
        if (q_up)      phs_d = phs_q + 1'b1;
        else if (q_dn) phs_d = phs_q - 1'b1;
      end
      default: ;
    endcase
    if (wr_phs) begin
      phs_d = wr_data_i;
      wrap  = 1'b0;
    end
    if (wrap)               out_d = ~out_q;
    else if (max_q == '0)   out_d = phs_d[W-1];
    else                    out_d = out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      psel_q  <= '0;
      src_a_q <= 1'b0;
      src_b_q <= 1'b0;
      frq_q   <= '0;
      max_q   <= '0;
      phs_q   <= '0;
      out_q   <= 1'b0;
      ab_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q  <= mode_e'(wr_data_i[1:0]);
        psel_q  <= wr_data_i[CTRL_PSEL_LSB +: SEL_W];
        src_a_q <= wr_data_i[CTRL_SRCA_BIT];
        src_b_q <= wr_data_i[CTRL_SRCB_BIT];
      end
      if (wr_frq) frq_q <= wr_data_i;
      if (wr_max) max_q <= wr_data_i;
      phs_q <= phs_d;
      out_q <= out_d;
      ab_q  <= ab_s;
    end
  end

  assign phs_o = phs_q;
  assign out_o = out_q;
endmodule

// File: rtl/nco_counter_cell_chk.sv
module nco_counter_cell_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   mode_i,
  input logic         tick_i,
  input logic [W-1:0] frq_i,
  input logic [W-1:0] max_i,
  input logic [W-1:0] phs_i,
  input logic         out_i,
  input logic         wr_en_i,
  input logic [1:0]   wr_addr_i,
  input logic [W-1:0] wr_data_i
);
  logic phs_wr, max_wr;
  assign phs_wr = wr_en_i && (wr_addr_i == 2'd2);
  assign max_wr = wr_en_i && (wr_addr_i == 2'd3);

  AST_NCO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && tick_i && max_i == '0 && !phs_wr)
      |=> phs_i == $past(phs_i) + $past(frq_i)); // R2

  AST_CEIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && max_i != '0 && phs_i < max_i && !phs_wr && !max_wr)
      |=> phs_i < $past(max_i)); // R4

  AST_OUT_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_i == '0) |=> out_i == phs_i[W-1]); // R5

  AST_QUAD_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !phs_wr)
      |=> (phs_i == $past(phs_i)) || (phs_i == $past(phs_i) + 1'b1)
          || (phs_i == $past(phs_i) - 1'b1)); // R7

  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phs_wr |=> phs_i == $past(wr_data_i)); // R9

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !phs_wr) |=> $stable(phs_i)); // R10
endmodule

bind nco_counter_cell nco_counter_cell_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_q),
  .tick_i   (tick),
  .frq_i    (frq_q),
  .max_i    (max_q),
  .phs_i    (phs_q),
  .out_i    (out_q),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i)
);

// File: tb/nco_counter_cell_bench.sv
module nco_counter_cell_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pin_a = 1'b0, pin_b = 1'b0, partner = 1'b0;
  logic [31:0] phs;
  logic        out;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  nco_counter_cell u_nco_counter_cell (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pin_a_i(pin_a), .pin_b_i(pin_b),
    .partner_i(partner), .phs_o(phs), .out_o(out)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctrl(int mode, int psel, bit sa, bit sb);
    return 32'(mode) | (32'(psel) << 2) | (32'(sa) << 5) | (32'(sb) << 6);
  endfunction

  task automatic setup(int mode, int psel, logic [31:0] frq, logic [31:0] p0, logic [31:0] mx);
    wr(2'd0, 32'd0);
    wr(2'd1, frq);
    wr(2'd2, p0);
    wr(2'd3, mx);
    wr(2'd0, ctrl(mode, psel, 1'b0, 1'b0));
  endtask

  task automatic t_reset;
    check("R1 phase", phs, 32'd0);
    check("R1 out", {31'd0, out}, 32'd0);
  endtask

  task automatic t_nco;
    setup(1, 0, 32'd7, 32'd0, 32'd0);
    step(5);
    check("R2 five adds", phs, 32'd35);
  endtask

  task automatic t_presc;
    for (int k = 1; k <= 4; k++) begin
      setup(1, k, 32'd1, 32'd0, 32'd0);
      step((1 << k) - 1);
      check("R3 before first tick", phs, 32'd0);
      step(41 - (1 << k));
      check("R3 forty clocks", phs, 32'(40 >> k));
    end
  endtask

  task automatic t_ceiling;
    setup(1, 0, 32'd3, 32'd0, 32'd10);
    check("R4 out start", {31'd0, out}, 32'd0);
    step(3);
    check("R4 below ceiling", phs, 32'd9);
    step(1);
    check("R4 rollover phase", phs, 32'd0);
    check("R4 rollover toggles", {31'd0, out}, 32'd1);
    step(2);
    check("R4 resume", phs, 32'd6);
    check("R4 out held", {31'd0, out}, 32'd1);
    step(2);
    check("R4 second toggle", {31'd0, out}, 32'd0);
  endtask

  task automatic t_wrap;
    setup(1, 0, 32'd16, 32'hFFFF_FFF0, 32'd0);
    check("R5 msb before", {31'd0, out}, 32'd1);
    step(1);
    check("R5 wrap", phs, 32'd0);
    check("R5 msb after wrap", {31'd0, out}, 32'd0);
    setup(1, 0, 32'd1, 32'h7FFF_FFFF, 32'd0);
    step(1);
    check("R5 msb rise", {31'd0, out}, 32'd1);
  endtask

  task automatic t_prio;
    setup(1, 0, 32'd5, 32'd0, 32'd0);
    step(3);
    wr(2'd2, 32'd100);
    check("R9 write wins", phs, 32'd100);
    step(1);
    check("R9 resumes", phs, 32'd105);
  endtask

  task automatic pulse_a;
    pin_a = 1'b1; step(4);
    pin_a = 1'b0; step(4);
  endtask

  task automatic t_off;
    setup(0, 0, 32'd9, 32'd77, 32'd0);
    pin_b = 1'b1; pulse_a(); pin_b = 1'b0; step(10);
    check("R10 hold", phs, 32'd77);
  endtask

  task automatic t_gated;
    pin_a = 1'b0; pin_b = 1'b0; step(4);
    setup(2, 0, 32'd0, 32'd0, 32'd0);
    repeat (3) pulse_a();
    check("R6 B low", phs, 32'd0);
    pin_b = 1'b1; step(4);
    repeat (3) pulse_a();
    check("R6 B high", phs, 32'd3);
    pin_a = 1'b1; step(4);
    check("R6 rise only", phs, 32'd4);
    pin_a = 1'b0; step(4);
    check("R6 fall ignored", phs, 32'd4);
  endtask

  task automatic t_sync;
    pin_a = 1'b1;
    step(2);
    check("R11 two edges", phs, 32'd4);
    step(1);
    check("R11 third edge", phs, 32'd5);
    pin_a = 1'b0; pin_b = 1'b0; step(4);
  endtask

  task automatic t_quad;
    setup(3, 0, 32'd0, 32'd0, 32'd0);
    pin_a = 1'b1; step(4); pin_b = 1'b1; step(4);
    pin_a = 1'b0; step(4); pin_b = 1'b0; step(4);
    check("R7 forward", phs, 32'd4);
    repeat (2) begin
      pin_b = 1'b1; step(4); pin_a = 1'b1; step(4);
      pin_b = 1'b0; step(4); pin_a = 1'b0; step(4);
    end
    check("R7 reverse", phs, 32'hFFFF_FFFC);
    check("R7 out msb", {31'd0, out}, 32'd1);
    pin_a = 1'b1; pin_b = 1'b1; step(4);
    pin_a = 1'b0; pin_b = 1'b0; step(4);
    check("R7 illegal step", phs, 32'hFFFF_FFFC);
  endtask

  task automatic t_src;
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd0);
    pin_b = 1'b1;
    wr(2'd0, ctrl(2, 0, 1'b1, 1'b0));
    step(4);
    repeat (2) begin
      partner = 1'b1; step(4); partner = 1'b0; step(4);
    end
    check("R8 partner on A", phs, 32'd2);
    pulse_a();
    check("R8 pin A ignored", phs, 32'd2);
    pin_b = 1'b0;
    wr(2'd0, ctrl(2, 0, 1'b0, 1'b1));
    partner = 1'b1; step(4);
    pulse_a();
    check("R8 partner on B", phs, 32'd3);
    partner = 1'b0; step(4);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_nco();
    t_presc();
    t_ceiling();
    t_wrap();
    t_prio();
    t_off();
    t_gated();
    t_sync();
    t_quad();
    t_src();
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule